// File: doc/BRIEF.md
# AHB Burst Flattening Bridge

This bridge sits on a point-to-point AHB-Lite link between one master and one slave. It turns every beat of any burst the master issues into a standalone single transfer toward the slave. Sequential beats become NONSEQ. BUSY cycles become IDLE. The burst type is forced to SINGLE. As a result, a slave behind the bridge never has to understand bursts. This matters most for slaves whose latency is unknown or unbounded.

The handshake with the master stays correct beat by beat. Slave wait states stall the master through the ready output, and the two-cycle ERROR response is relayed unchanged. Each beat keeps its own address, size, direction, protection bits and write data. Address, data and response paths are combinational, so the bridge adds no latency.

One pairing may keep its bursts. When `bypass_en` is high at the moment a burst's first beat is accepted, that whole burst passes through untouched. The captured choice holds for all later beats, whatever `bypass_en` does after that.

Top module: `ahb_burst_flattener`

## Requirements
- R1: Each beat's address, size, write flag, protection bits and write data appear unchanged on the downstream port in the same cycle.
- R2: In converted mode, an upstream SEQ (2'b11) is issued downstream as NONSEQ (2'b10), and NONSEQ stays NONSEQ.
- R3: In converted mode, the downstream burst type is SINGLE (3'b000) whatever the master sends.
- R4: In converted mode, an upstream BUSY (2'b01) is presented downstream as IDLE (2'b00).
- R5: `bypass_en` is captured when an upstream NONSEQ is accepted (up_htrans 2'b10 with dn_hready high). SEQ and BUSY beats use the captured value; IDLE and NONSEQ cycles use the live `bypass_en`. In bypass mode, transfer type and burst type pass unchanged.
- R6: up_hreadyout follows dn_hready and up_hrdata follows dn_hrdata in the same cycle, so slave wait states stall the master.
- R7: up_hresp follows dn_hresp in both cycles of an ERROR response (1 = ERROR).
- R8: An upstream IDLE is always IDLE downstream, including when a master abandons a burst after an ERROR.
- R9: Reset clears the captured bypass choice, so a SEQ or BUSY seen before any accepted NONSEQ is converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bypass_en | input | 1 | Requests burst pass-through for the burst starting now |
| up_haddr | input | ADDR_W | Master address |
| up_htrans | input | 2 | Master transfer type |
| up_hburst | input | 3 | Master burst type |
| up_hsize | input | 3 | Master transfer size |
| up_hwrite | input | 1 | Master write flag |
| up_hprot | input | 4 | Master protection bits |
| up_hwdata | input | DATA_W | Master write data |
| up_hreadyout | output | 1 | Ready returned to master |
| up_hresp | output | 1 | Response returned to master |
| up_hrdata | output | DATA_W | Read data returned to master |
| dn_haddr | output | ADDR_W | Slave address |
| dn_htrans | output | 2 | Slave transfer type |
| dn_hburst | output | 3 | Slave burst type |
| dn_hsize | output | 3 | Slave transfer size |
| dn_hwrite | output | 1 | Slave write flag |
| dn_hprot | output | 4 | Slave protection bits |
| dn_hwdata | output | DATA_W | Slave write data |
| dn_hready | input | 1 | Slave ready |
| dn_hresp | input | 1 | Slave response |
| dn_hrdata | input | DATA_W | Slave read data |

## Verification
The hardest case to reach is a burst whose opening NONSEQ is accepted with bypass in one state, while `bypass_en` flips before its later SEQ or BUSY beats. A variant holds the NONSEQ in wait states while bypass changes, so that only the value at the accepting edge counts. The random stimulus toggles `bypass_en` independently every cycle, and the ready signal is often low. Directed sequences also force a bypass flip in the middle of a burst, a stalled first beat, and an ERROR followed by an IDLE abandon.

// File: rtl/ahb_burst_flattener.sv
module ahb_burst_flattener #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic [ADDR_W-1:0] up_haddr,
  input  logic [1:0]        up_htrans,
  input  logic [2:0]        up_hburst,
  input  logic [2:0]        up_hsize,
  input  logic              up_hwrite,
  input  logic [3:0]        up_hprot,
  input  logic [DATA_W-1:0] up_hwdata,
  output logic              up_hreadyout,
  output logic              up_hresp,
  output logic [DATA_W-1:0] up_hrdata,
  output logic [ADDR_W-1:0] dn_haddr,
  output logic [1:0]        dn_htrans,
  output logic [2:0]        dn_hburst,
  output logic [2:0]        dn_hsize,
  output logic              dn_hwrite,
  output logic [3:0]        dn_hprot,
  output logic [DATA_W-1:0] dn_hwdata,
  input  logic              dn_hready,
  input  logic              dn_hresp,
  input  logic [DATA_W-1:0] dn_hrdata
);
  localparam logic [1:0] T_IDLE   = 2'b00;
  localparam logic [1:0] T_BUSY   = 2'b01;
  localparam logic [1:0] T_NONSEQ = 2'b10;
  localparam logic [1:0] T_SEQ    = 2'b11;
  localparam logic [2:0] B_SINGLE = 3'b000;

  logic byp_hold;
  logic mid_burst;
  logic byp_eff;

  assign mid_burst = (up_htrans == T_SEQ) || (up_htrans == T_BUSY);
  assign byp_eff   = mid_burst ? byp_hold : bypass_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      byp_hold <= 1'b0;
    else if (up_htrans == T_NONSEQ && dn_hready)
      byp_hold <= bypass_en;
  end

  always_comb begin
    if (byp_eff) begin
      dn_htrans = up_htrans;
    end else begin
      case (up_htrans)
        T_SEQ, T_NONSEQ: dn_htrans = T_NONSEQ;
        default:         dn_htrans = T_IDLE;
      endcase
    end
  end

  assign dn_hburst    = byp_eff ? up_hburst : B_SINGLE;
  assign dn_haddr     = up_haddr;
  assign dn_hsize     = up_hsize;
  assign dn_hwrite    = up_hwrite;
  assign dn_hprot     = up_hprot;
  assign dn_hwdata    = up_hwdata;
  assign up_hreadyout = dn_hready;
  assign up_hresp     = dn_hresp;
  assign up_hrdata    = dn_hrdata;

  // R3: a first beat without bypass never reaches the slave as a burst
  a_r3_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (up_htrans == T_NONSEQ && !bypass_en) |-> dn_hburst == B_SINGLE);

  // R2: converted sequential beat carries no SEQ downstream
  a_r2_seq_flattened: assert property (@(posedge clk) disable iff (!rst_n)
    (up_htrans == T_SEQ && $past(up_htrans == T_NONSEQ && up_hreadyout && !bypass_en))
      |-> dn_htrans == T_NONSEQ);

  // R5: bypass chosen at the accepted first beat survives a later flip of bypass_en
  a_r5_bypass_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (up_htrans == T_SEQ && $past(up_htrans == T_NONSEQ && up_hreadyout && bypass_en))
      |-> (dn_htrans == T_SEQ && dn_hburst == up_hburst));

  // R6: slave wait state stalls the master
  a_r6_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_hready |-> !up_hreadyout);

  // R7: first ERROR cycle reaches the master as error with ready low
  a_r7_error_relay: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_hresp && !dn_hready) |-> (up_hresp && !up_hreadyout));

  // R8: master idle never becomes a slave transfer
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    up_htrans == T_IDLE |-> dn_htrans == T_IDLE);
endmodule

// File: tb/ahb_burst_flattener_test.sv
`timescale 1ns/1ps
module ahb_burst_flattener_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass_en = 1'b0;
  logic [31:0] up_haddr = '0;
  logic [1:0]  up_htrans = 2'b00;
  logic [2:0]  up_hburst = '0;
  logic [2:0]  up_hsize = '0;
  logic        up_hwrite = 1'b0;
  logic [3:0]  up_hprot = '0;
  logic [31:0] up_hwdata = '0;
  logic        up_hreadyout, up_hresp;
  logic [31:0] up_hrdata;
  logic [31:0] dn_haddr;
  logic [1:0]  dn_htrans;
  logic [2:0]  dn_hburst, dn_hsize;
  logic        dn_hwrite;
  logic [3:0]  dn_hprot;
  logic [31:0] dn_hwdata;
  logic        dn_hready = 1'b1;
  logic        dn_hresp = 1'b0;
  logic [31:0] dn_hrdata = '0;

  int checks = 0;
  int fails = 0;
  logic m_hold = 1'b0;

  always #4 clk = ~clk;

  ahb_burst_flattener uut (.*);

  function automatic logic [1:0] exp_trans(input logic [1:0] t, input logic eff);
    if (eff) return t;
    if (t == 2'b11 || t == 2'b10) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] t, input logic [2:0] b, input logic byp,
                      input logic rdy, input logic rsp);
    logic eff;
    @(negedge clk);
    up_htrans = t; up_hburst = b; bypass_en = byp; dn_hready = rdy; dn_hresp = rsp;
    up_haddr = $urandom; up_hsize = 3'($urandom); up_hwrite = 1'($urandom);
    up_hprot = 4'($urandom); up_hwdata = $urandom; dn_hrdata = $urandom;
    #1;
    eff = (t == 2'b11 || t == 2'b01) ? m_hold : byp;
    chk("R1 addr", 64'(dn_haddr), 64'(up_haddr));
    chk("R1 ctrl", 64'({dn_hsize, dn_hwrite, dn_hprot}), 64'({up_hsize, up_hwrite, up_hprot}));
    chk("R1 wdata", 64'(dn_hwdata), 64'(up_hwdata));
    chk("R2/R4/R5/R8 htrans", 64'(dn_htrans), 64'(exp_trans(t, eff)));
    chk("R3/R5 hburst", 64'(dn_hburst), 64'(eff ? b : 3'b000));
    chk("R6 ready", 64'(up_hreadyout), 64'(rdy));
    chk("R6 rdata", 64'(up_hrdata), 64'(dn_hrdata));
    chk("R7 resp", 64'(up_hresp), 64'(rsp));
    @(posedge clk);
    if (t == 2'b10 && rdy) m_hold = byp;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: after reset a stray SEQ and BUSY are converted even with bypass requested
    step(2'b11, 3'b011, 1'b1, 1'b1, 1'b0);
    step(2'b01, 3'b011, 1'b1, 1'b1, 1'b0);
    // R2 R3 R4: converted INCR4 with a BUSY and a wait state
    step(2'b10, 3'b011, 1'b0, 1'b1, 1'b0);
    step(2'b11, 3'b011, 1'b0, 1'b0, 1'b0);
    step(2'b11, 3'b011, 1'b0, 1'b1, 1'b0);
    step(2'b01, 3'b011, 1'b0, 1'b1, 1'b0);
    step(2'b11, 3'b011, 1'b0, 1'b1, 1'b0);
    // R5: bypass burst, bypass_en drops mid-burst; BUSY passes as BUSY
    step(2'b10, 3'b101, 1'b1, 1'b1, 1'b0);
    step(2'b11, 3'b101, 1'b0, 1'b1, 1'b0);
    step(2'b01, 3'b101, 1'b0, 1'b1, 1'b0);
    step(2'b11, 3'b101, 1'b0, 1'b1, 1'b0);
    // R5: first beat stalled while bypass flips; only the accepting edge counts
    step(2'b10, 3'b010, 1'b1, 1'b0, 1'b0);
    step(2'b10, 3'b010, 1'b0, 1'b1, 1'b0);
    step(2'b11, 3'b010, 1'b1, 1'b1, 1'b0);
    // R7 R8: ERROR on a beat, master abandons with IDLE
    step(2'b10, 3'b001, 1'b0, 1'b1, 1'b0);
    step(2'b11, 3'b001, 1'b0, 1'b0, 1'b1);
    step(2'b00, 3'b001, 1'b0, 1'b1, 1'b1);
    step(2'b00, 3'b001, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = ($urandom % 4) != 0;
      step(2'($urandom), 3'($urandom), 1'($urandom), r, (!r) ? 1'($urandom) : 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule